// File: doc/BRIEF.md
# Serial Data-Link Frame Receiver with Address Match

This block sits behind a T1 extended-superframe framer and takes the data-link channel one bit at a time, one bit for each cycle in which `bit_en` is high. It hunts for flag octets (a zero, six ones, a zero), aligns bytes to them and removes the zeros a sender inserts after five ones. Payload bytes are assembled least significant bit first and handed out through a one-deep holding register.

A host loads two match values. Only the first byte after an opening flag is compared with them. A hit pulses `match_stb`, sets a sticky match flag and arms the receiver. The sticky link-event flag `st_link` is set by every abort (eight ones in a row). While the receiver is armed, the closing flag of the frame also sets it, so a host that waits on one bit learns that a message it cares about is complete. Both sticky flags stay set until `clr_status` is pulsed.

The output side follows valid/ready. `rx_valid` rises with every new byte and stays high until the host accepts the byte with `rx_ready`. The line cannot be paused, so there is no back-pressure toward the link. If a new byte completes while the old one is still held, the register takes the new byte and `rx_valid` stays high. `byte_stb` pulses once per byte whether or not the host is ready.

Top module: `dl_flag_rx`

## Requirements
- R1: After reset, and after each closing flag, the receiver hunts. Data bits seen before an opening flag (0 1 1 1 1 1 1 0 in arrival order) produce no byte.
- R2: Inside a frame, a 0 bit that follows five consecutive 1 bits is discarded and is not part of any byte.
- R3: Bytes are assembled with the first received data bit in bit 0. Each byte appears on `rx_data` together with a `byte_stb` pulse that lasts one clock.
- R4: `rx_valid` is set with each byte and held, with `rx_data` stable, until a cycle with `rx_ready` high. A byte completing while `rx_valid` is high replaces the held byte.
- R5: Back-to-back flags keep a frame open without producing a byte. A partial byte cut off by a flag is discarded.
- R6: If the first byte after an opening flag equals match register 0 (`match_vals[7:0]`) or match register 1 (`match_vals[15:8]`), then `match_stb` pulses with that byte's `byte_stb`, and `st_match` and `link_armed` are set.
- R7: Bytes after the first in a frame never raise `match_stb`, even when they equal a match value.
- R8: Eight consecutive 1s set `st_link`, clear `link_armed` and return the receiver to hunting. The byte just before the abort and any partial byte are dropped, and no byte follows until the next flag.
- R9: A closing flag while armed sets `st_link` and clears `link_armed`. A closing flag while not armed leaves `st_link` unchanged.
- R10: The flag that closes a frame does not open the next one. Payload bits sent before another flag are ignored.
- R11: `st_match` and `st_link` stay set until a `clr_status` pulse clears them.
- R12: Reset leaves `rx_valid`, `byte_stb`, `match_stb`, `st_match`, `st_link` and `link_armed` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bit_en | input | 1 | A new link bit is present on `bit_in` |
| bit_in | input | 1 | Link data bit |
| match_vals | input | NMATCH*DW | Match registers, register i in bits [8i+7:8i] |
| clr_status | input | 1 | Clears the sticky status flags |
| rx_data | output | DW | Received byte |
| rx_valid | output | 1 | `rx_data` holds a byte not yet accepted |
| rx_ready | input | 1 | Host accepts the held byte |
| byte_stb | output | 1 | One-clock pulse per received byte |
| match_stb | output | 1 | One-clock pulse on an address match |
| st_match | output | 1 | Sticky: a match occurred |
| st_link | output | 1 | Sticky: abort, or closing flag while armed |
| link_armed | output | 1 | A matched frame is in progress |

## Verification
The most likely internal fault is byte alignment drifting by a bit, for example through a missed flag or a wrong count of held-back bits. At the ports this shows up within one byte as a shifted or lost payload value. Comparing every delivered byte with the transmitted payload catches it on the first frame. A fault in the ones counter shows in the stuffing and abort cases, as an extra 0 inside a byte or as missing status, within the frame concerned. A fault in the armed state shows at the closing flag, where `st_link` must follow the match result of that frame and nothing else.

// File: rtl/dlrx_pkg.sv
package dlrx_pkg;
  // run lengths of 1 bits that give a bit its meaning
  localparam int STUFF_RUN = 5;
  localparam int FLAG_RUN  = 6;
  localparam int ABORT_RUN = 8;

  typedef enum logic {
    FR_HUNT = 1'b0,
    FR_OPEN = 1'b1
  } frame_state_e;
endpackage

// File: rtl/dl_bit_front.sv
// Classifies each incoming bit (data, stuffed zero, flag end, abort) and
// holds data bits back long enough to drop the leading bits of a flag.
module dl_bit_front
  import dlrx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  output logic emit_vld,
  output logic emit_bit,
  output logic flag_evt,
  output logic abort_evt
);
  localparam int HOLD = DW - 1;
  localparam int CW   = $clog2(HOLD + 1);
  localparam int OW   = $clog2(ABORT_RUN + 1);
  localparam logic [OW-1:0] K_STUFF = OW'(STUFF_RUN);
  localparam logic [OW-1:0] K_FLAG  = OW'(FLAG_RUN);
  localparam logic [OW-1:0] K_ABORT = OW'(ABORT_RUN);
  localparam logic [CW-1:0] K_HOLD  = CW'(HOLD);

  logic [OW-1:0]   ones_q;
  logic [HOLD-1:0] hold_q;
  logic [CW-1:0]   fill_q;
  logic            push;
  logic            full;

  always_comb begin
    flag_evt  = bit_en && !bit_in && (ones_q == K_FLAG);
    abort_evt = bit_en &&  bit_in && (ones_q == K_ABORT - 1'b1);
    // a 1 after six ones and a 0 after five or more ones are never data
    push      = bit_en && !(bit_in && (ones_q >= K_FLAG))
                       && !(!bit_in && (ones_q >= K_STUFF));
    full      = (fill_q == K_HOLD);
    emit_vld  = push && full;
    emit_bit  = hold_q[HOLD-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
      hold_q <= '0;
      fill_q <= '0;
    end else if (bit_en) begin
      if (bit_in) begin
        if (ones_q != K_ABORT) ones_q <= ones_q + 1'b1;
      end else begin
        ones_q <= '0;
      end
      if (flag_evt || abort_evt) begin
        fill_q <= '0;
      end else if (push) begin
        hold_q <= {hold_q[HOLD-2:0], bit_in};
        if (!full) fill_q <= fill_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dl_byte_asm.sv
// Packs data bits LSB first into a word; `done` marks the completing bit.
module dl_byte_asm #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          in_vld,
  input  logic          in_bit,
  output logic          done,
  output logic [DW-1:0] word
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] K_LAST = CW'(DW - 1);

  logic [DW-1:0] sr_q;
  logic [CW-1:0] cnt_q;

  always_comb begin
    word = {in_bit, sr_q[DW-1:1]};
    done = in_vld && !clear && (cnt_q == K_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (in_vld) begin
      sr_q  <= word;
      cnt_q <= done ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dl_match_unit.sv
// Compares a byte with each programmed match value.
module dl_match_unit #(
  parameter int DW     = 8,
  parameter int NMATCH = 2
) (
  input  logic [DW-1:0]        word,
  input  logic [NMATCH*DW-1:0] refs,
  output logic                 hit
);
  logic [NMATCH-1:0] eq;

  for (genvar i = 0; i < NMATCH; i++) begin : g_cmp
    assign eq[i] = (refs[i*DW +: DW] == word);
  end

  assign hit = |eq;
endmodule

// File: rtl/dl_flag_rx.sv
module dl_flag_rx
  import dlrx_pkg::*;
#(
  parameter int DW     = 8,
  parameter int NMATCH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_en,
  input  logic                 bit_in,
  input  logic [NMATCH*DW-1:0] match_vals,
  input  logic                 clr_status,
  output logic [DW-1:0]        rx_data,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic                 byte_stb,
  output logic                 match_stb,
  output logic                 st_match,
  output logic                 st_link,
  output logic                 link_armed
);
  frame_state_e state_q;
  logic         got_byte_q;
  logic         emit_vld, emit_bit, flag_evt, abort_evt;
  logic         asm_clear, asm_done;
  logic [DW-1:0] asm_word;
  logic         hit;
  logic         byte_ok, first_hit, frame_end, set_link;

  dl_bit_front #(.DW(DW)) u_front (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .emit_vld(emit_vld), .emit_bit(emit_bit),
    .flag_evt(flag_evt), .abort_evt(abort_evt)
  );

  assign asm_clear = flag_evt || abort_evt || (state_q == FR_HUNT);

  dl_byte_asm #(.DW(DW)) u_asm (
    .clk(clk), .rst_n(rst_n), .clear(asm_clear),
    .in_vld(emit_vld), .in_bit(emit_bit),
    .done(asm_done), .word(asm_word)
  );

  dl_match_unit #(.DW(DW), .NMATCH(NMATCH)) u_match (
    .word(asm_word), .refs(match_vals), .hit(hit)
  );

  always_comb begin
    byte_ok   = asm_done && (state_q == FR_OPEN);
    first_hit = byte_ok && !got_byte_q && hit;
    frame_end = flag_evt && (state_q == FR_OPEN) && got_byte_q;
    set_link  = abort_evt || (frame_end && link_armed);
  end

  // frame tracking and armed state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= FR_HUNT;
      got_byte_q <= 1'b0;
      link_armed <= 1'b0;
    end else begin
      if (abort_evt || frame_end) begin
        state_q    <= FR_HUNT;
        got_byte_q <= 1'b0;
        link_armed <= 1'b0;
      end else if (flag_evt && state_q == FR_HUNT) begin
        state_q    <= FR_OPEN;
        got_byte_q <= 1'b0;
      end else if (byte_ok) begin
        got_byte_q <= 1'b1;
        if (first_hit) link_armed <= 1'b1;
      end
    end
  end

  // output holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      byte_stb  <= 1'b0;
      match_stb <= 1'b0;
    end else begin
      byte_stb  <= byte_ok;
      match_stb <= first_hit;
      if (byte_ok) begin
        rx_data  <= asm_word;
        rx_valid <= 1'b1;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end

  // sticky status, an event in the clear cycle wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_match <= 1'b0;
      st_link  <= 1'b0;
    end else begin
      if (first_hit)       st_match <= 1'b1;
      else if (clr_status) st_match <= 1'b0;
      if (set_link)        st_link  <= 1'b1;
      else if (clr_status) st_link  <= 1'b0;
    end
  end
endmodule

// File: rtl/dl_flag_rx_chk.sv
module dl_flag_rx_chk #(
  parameter int DW     = 8,
  parameter int NMATCH = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bit_en,
  input logic [NMATCH*DW-1:0] match_vals,
  input logic                 clr_status,
  input logic [DW-1:0]        rx_data,
  input logic                 rx_valid,
  input logic                 rx_ready,
  input logic                 byte_stb,
  input logic                 match_stb,
  input logic                 st_match,
  input logic                 st_link,
  input logic                 link_armed
);
  logic any_eq;
  always_comb begin
    any_eq = 1'b0;
    for (int i = 0; i < NMATCH; i++)
      if (match_vals[i*DW +: DW] == rx_data) any_eq = 1'b1;
  end

  AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n) byte_stb |=> !byte_stb); // R3
  AST_STB_FROM_BIT: assert property (@(posedge clk) disable iff (!rst_n) byte_stb |-> $past(bit_en)); // R3
  AST_VALID_ON_STB: assert property (@(posedge clk) disable iff (!rst_n) byte_stb |-> rx_valid); // R4
  AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n) rx_valid && !rx_ready |=> rx_valid); // R4
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n) rx_valid && !rx_ready |=> byte_stb || $stable(rx_data)); // R4
  AST_MATCH_VALUE: assert property (@(posedge clk) disable iff (!rst_n) match_stb |-> byte_stb && any_eq); // R6
  AST_MATCH_ARMS: assert property (@(posedge clk) disable iff (!rst_n) match_stb |-> link_armed && st_match); // R6
  AST_DISARM_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) $fell(link_armed) |-> st_link); // R9
  AST_LINK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) st_link && !clr_status |=> st_link); // R11
  AST_MATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n) st_match && !clr_status |=> st_match); // R11
endmodule

bind dl_flag_rx dl_flag_rx_chk #(.DW(DW), .NMATCH(NMATCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .match_vals(match_vals),
  .clr_status(clr_status), .rx_data(rx_data), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .byte_stb(byte_stb), .match_stb(match_stb),
  .st_match(st_match), .st_link(st_link), .link_armed(link_armed)
);

// File: tb/test_dl_flag_rx.sv
module test_dl_flag_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic        bit_in = 1'b0;
  logic [15:0] match_vals;
  logic        clr_status = 1'b0;
  logic [7:0]  rx_data;
  logic        rx_valid;
  logic        rx_ready = 1'b1;
  logic        byte_stb, match_stb, st_match, st_link, link_armed;

  localparam logic [7:0] M0 = 8'h03;
  localparam logic [7:0] M1 = 8'h41;
  assign match_vals = {M1, M0};

  always #5 clk = ~clk;

  dl_flag_rx i_dl_flag_rx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .match_vals(match_vals), .clr_status(clr_status),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .byte_stb(byte_stb), .match_stb(match_stb), .st_match(st_match),
    .st_link(st_link), .link_armed(link_armed)
  );

  int errs = 0;
  int checks = 0;
  int tx_ones = 0;
  int match_seen = 0;
  logic [7:0] got[$];
  logic [7:0] pl[$];

  always @(negedge clk) begin
    if (byte_stb) got.push_back(rx_data);
    if (match_stb) match_seen++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tx_bit(input bit b);
    int gap;
    gap = $urandom_range(0, 2);
    bit_en = 1'b1;
    bit_in = b;
    @(negedge clk);
    bit_en = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic tx_flag();
    tx_bit(1'b0);
    for (int i = 0; i < 6; i++) tx_bit(1'b1);
    tx_bit(1'b0);
    tx_ones = 0;
  endtask

  task automatic tx_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      tx_bit(v[i]);
      if (v[i]) begin
        tx_ones++;
        if (tx_ones == 5) begin
          tx_bit(1'b0);
          tx_ones = 0;
        end
      end else begin
        tx_ones = 0;
      end
    end
  endtask

  task automatic tx_frame();
    tx_flag();
    foreach (pl[i]) tx_byte(pl[i]);
    tx_flag();
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_bytes(input string req);
    chk(got.size() == pl.size(), req, got.size(), pl.size());
    if (got.size() == pl.size())
      foreach (pl[i]) chk(got[i] == pl[i], req, got[i], pl[i]);
    got.delete();
  endtask

  task automatic clr_pulse();
    clr_status = 1'b1;
    @(negedge clk);
    clr_status = 1'b0;
    @(negedge clk);
  endtask

  function automatic bit is_match(input logic [7:0] v);
    return (v == M0) || (v == M1);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int ms;
    logic [7:0] v;
    bit exp_m;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk(!rx_valid && !byte_stb && !match_stb, "R12", {rx_valid, byte_stb, match_stb}, 0);
    chk(!st_match && !st_link && !link_armed, "R12", {st_match, st_link, link_armed}, 0);

    // R1 bits before any flag give nothing
    for (int i = 0; i < 24; i++) tx_bit(i[0]);
    repeat (3) @(negedge clk);
    chk(got.size() == 0, "R1", got.size(), 0);
    got.delete();

    // R2 stuffing-heavy payload
    pl = '{8'hFF, 8'h7E, 8'h3E, 8'hF8, 8'h1F};
    tx_frame();
    expect_bytes("R2");

    // R5 repeated flags and a partial byte cut by a flag
    pl = '{8'hA5, 8'h5C};
    tx_flag(); tx_flag();
    tx_bit(1'b1); tx_bit(1'b0); tx_bit(1'b1);
    tx_frame();
    expect_bytes("R5");

    // R10 payload after a closing flag, before the next flag, is ignored
    pl = '{8'h66};
    tx_frame();
    got.delete();
    tx_byte(8'h12); tx_byte(8'h34);
    repeat (3) @(negedge clk);
    chk(got.size() == 0, "R10", got.size(), 0);
    pl = '{8'h9C};
    tx_frame();
    expect_bytes("R10");

    // R4 host not ready: newest byte held, then accepted
    rx_ready = 1'b0;
    pl = '{8'h21, 8'hB7};
    tx_frame();
    chk(rx_valid == 1'b1, "R4", rx_valid, 1);
    chk(rx_data == 8'hB7, "R4", rx_data, 8'hB7);
    rx_ready = 1'b1;
    @(negedge clk);
    chk(rx_valid == 1'b0, "R4", rx_valid, 0);
    expect_bytes("R4");

    // R8 abort inside an armed frame
    clr_pulse();
    ms = match_seen;
    tx_flag();
    tx_byte(M0); tx_byte(8'h12); tx_byte(8'h34);
    for (int i = 0; i < 8; i++) tx_bit(1'b1);
    tx_bit(1'b0);
    tx_ones = 0;
    tx_byte(8'h99); tx_byte(8'h5A);
    repeat (3) @(negedge clk);
    pl = '{M0, 8'h12};
    expect_bytes("R8");
    chk(match_seen == ms + 1, "R8", match_seen - ms, 1);
    chk(st_link == 1'b1, "R8", st_link, 1);
    chk(link_armed == 1'b0, "R8", link_armed, 0);

    // R11 clear
    clr_pulse();
    chk(!st_link && !st_match, "R11", {st_link, st_match}, 0);

    // R9 unarmed close leaves st_link low
    pl = '{8'h77, M1};
    tx_frame();
    expect_bytes("R9");
    chk(st_link == 1'b0, "R9", st_link, 0);
    chk(st_match == 1'b0, "R7", st_match, 0);

    // random frames: R3 R6 R7 R9 R11
    for (int f = 0; f < 40; f++) begin
      int n;
      n = $urandom_range(1, 6);
      pl.delete();
      case ($urandom_range(0, 2))
        0: v = M0;
        1: v = M1;
        default: v = 8'($urandom());
      endcase
      pl.push_back(v);
      exp_m = is_match(v);
      for (int k = 1; k < n; k++)
        pl.push_back(($urandom_range(0, 3) == 0) ? M1 : 8'($urandom()));
      clr_pulse();
      ms = match_seen;
      if ($urandom_range(0, 1) == 1) tx_flag();
      tx_frame();
      expect_bytes("R3");
      chk(match_seen == ms + int'(exp_m), "R7", match_seen - ms, int'(exp_m));
      chk(st_match == exp_m, "R6", st_match, exp_m);
      chk(st_link == exp_m, "R9", st_link, exp_m);
      chk(link_armed == 1'b0, "R9", link_armed, 0);
    end
    clr_pulse();
    chk(!st_link && !st_match, "R11", {st_link, st_match}, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule